// File: doc/BRIEF.md
# Debug Hart Handshake Register Bank

This block is a small register bank that sits inside a processor debug module. Harts that have entered debug mode run a fixed program that talks to the debugger through it. The hart side reaches it through a simple word-wide memory port. Writes to four fixed word offsets report events. One reports that the hart has halted. One acknowledges a go request. One acknowledges a resume request. One reports an exception taken while in debug mode. Reads from a flag region return one byte per hart, and each hart polls its own byte.

The debugger side has one-cycle request strobes. They set the go flag or the resume flag of a selected hart, and they clear a sticky exception indication. The bank drives the go flags, the resume flags, a per-hart halted status and the exception indication as plain outputs. A flag is raised only by the debugger. It is dropped only by the hart-side acknowledge write meant for it. When a raise and a drop of the same flag land in the same cycle, the drop wins.

Top module: `dbg_hs_regs`

## Requirements
- R1: After a synchronous active-low reset, all go flags, resume flags, halted bits and the exception indication are 0, and a read returns 0.
- R2: A `dbg_go_set` pulse sets bit `dbg_hart_sel` of `go_flags` at the next clock edge. A `dbg_resume_set` pulse sets the same bit of `resume_flags` at the next clock edge.
- R3: A hart-side word write to offset 0x104 clears the go flag of the hart given by `bus_src_hart`, and only that flag.
- R4: A word write to offset 0x108 clears both the resume flag and the halted bit of the hart whose ID equals the write data.
- R5: A word write to offset 0x100 sets the halted bit of the hart whose ID equals the write data. A write with an ID of `NUM_HARTS` or more changes nothing.
- R6: If a debugger set and a hart-side clear of the same hart's go or resume flag arrive in the same cycle, the flag ends up cleared.
- R7: Any word write to offset 0x10C sets `exception_seen`. It stays set until a `dbg_exc_clear` pulse clears it. If the report and the clear come in the same cycle, the indication stays set.
- R8: A read with an address in the range 0x400 to 0x7FF returns a 32-bit word one cycle later. Byte lane j of that word holds the flags of hart (address - 0x400, rounded down to a multiple of 4) + j. Bit 0 of the lane is the go flag, bit 1 is the resume flag, and the other bits are 0. Lanes for harts of index `NUM_HARTS` or more read 0.
- R9: A read outside the flag region returns 0. A write to any address that is not one of the four handshake offsets exactly (this includes the flag region and non-word-aligned addresses) changes nothing, and so does any cycle with `bus_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Hart-side access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the debug module |
| bus_wdata | input | DATA_W | Write data (a hart ID for 0x100 and 0x108) |
| bus_src_hart | input | ID_W | ID of the hart issuing the access |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| dbg_go_set | input | 1 | Debugger request: set the go flag of `dbg_hart_sel` |
| dbg_resume_set | input | 1 | Debugger request: set the resume flag of `dbg_hart_sel` |
| dbg_hart_sel | input | ID_W | Hart targeted by debugger requests |
| dbg_exc_clear | input | 1 | Debugger request: clear the exception indication |
| go_flags | output | NUM_HARTS | Go flag per hart |
| resume_flags | output | NUM_HARTS | Resume flag per hart |
| halted_harts | output | NUM_HARTS | Halted status per hart |
| exception_seen | output | 1 | Sticky debug-mode exception indication |

## Verification
Every status output is registered once, so a debugger request or a hart-side write shows its effect right after the clock edge that samples it. Read data is also registered once, so it is valid right after the edge that samples the read, and it shows the flag values from before that edge. The bench drives each stimulus on the falling edge, holds it across one rising edge, and checks the outputs on the next falling edge. That way every check lands one edge after its cause, and none lands later.

// File: rtl/dbg_hs_pkg.sv
// Package dbg_hs_pkg
// Shared offsets and the decoded-event type for the hart handshake bank.
// Assumes a byte address space of at least 12 bits.
package dbg_hs_pkg;
    localparam logic [11:0] OFS_HALT_RPT   = 12'h100;
    localparam logic [11:0] OFS_GO_ACK     = 12'h104;
    localparam logic [11:0] OFS_RESUME_ACK = 12'h108;
    localparam logic [11:0] OFS_EXC_RPT    = 12'h10C;
    localparam logic [11:0] OFS_FLAG_BASE  = 12'h400;
    localparam logic [11:0] OFS_FLAG_END   = 12'h800;

    typedef struct packed {
        logic halt_rpt;
        logic go_ack;
        logic resume_ack;
        logic exc_rpt;
        logic rd_any;
        logic rd_flags;
    } hs_evt_t;
endpackage

// File: rtl/dbg_hs_decode.sv
// Module dbg_hs_decode
// Turns one hart-side access into event strobes. Handshake writes must hit
// a word-aligned offset exactly. Reads are classified as flag-region or not.
// Assumes at most one access per cycle.
module dbg_hs_decode
    import dbg_hs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output hs_evt_t           evt
);
    logic wr;
    logic rd;
    logic in_flags;

    // Qualify the access type and the flag-region range.
    always_comb begin
        wr       = bus_req && bus_we;
        rd       = bus_req && !bus_we;
        in_flags = (bus_addr >= ADDR_W'(OFS_FLAG_BASE)) &&
                   (bus_addr <  ADDR_W'(OFS_FLAG_END));
    end

    // Match the exact handshake offsets.
    always_comb begin
        evt.halt_rpt   = wr && (bus_addr == ADDR_W'(OFS_HALT_RPT));
        evt.go_ack     = wr && (bus_addr == ADDR_W'(OFS_GO_ACK));
        evt.resume_ack = wr && (bus_addr == ADDR_W'(OFS_RESUME_ACK));
        evt.exc_rpt    = wr && (bus_addr == ADDR_W'(OFS_EXC_RPT));
        evt.rd_any     = rd;
        evt.rd_flags   = rd && in_flags;
    end
endmodule

// File: rtl/dbg_hs_hart_slice.sv
// Module dbg_hs_hart_slice
// Holds the go, resume and halted state of one hart. Clear strobes take
// priority over set strobes that arrive in the same cycle.
// Assumes the strobes are already qualified for this hart.
module dbg_hs_hart_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic go_set,
    input  logic go_clr,
    input  logic res_set,
    input  logic res_clr,
    input  logic halt_set,
    output logic go_q,
    output logic res_q,
    output logic halt_q
);
    // Go flag: the clear dominates.
    always_ff @(posedge clk) begin
        if (!rst_n)       go_q <= 1'b0;
        else if (go_clr)  go_q <= 1'b0;
        else if (go_set)  go_q <= 1'b1;
    end

    // Resume flag: the clear dominates.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= 1'b0;
        else if (res_clr) res_q <= 1'b0;
        else if (res_set) res_q <= 1'b1;
    end

    // Halted status: set on a halt report, cleared on a resume acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        halt_q <= 1'b0;
        else if (res_clr)  halt_q <= 1'b0;
        else if (halt_set) halt_q <= 1'b1;
    end

    assert_go_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_set && !go_clr) |=> go_q);
    assert_go_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go_clr |=> !go_q);
    assert_resume_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_clr |=> (!res_q && !halt_q));
    assert_halt_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_set && !res_clr) |=> halt_q);
endmodule

// File: rtl/dbg_hs_rdmux.sv
// Module dbg_hs_rdmux
// Registered read path. A flag-region read packs the flags of LANES
// consecutive harts into byte lanes. Any other read returns zero.
// Assumes DATA_W is a multiple of 8.
module dbg_hs_rdmux
    import dbg_hs_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_any,
    input  logic                 rd_flags,
    input  logic [ADDR_W-3:0]    addr_word,
    input  logic [NUM_HARTS-1:0] go_vec,
    input  logic [NUM_HARTS-1:0] res_vec,
    output logic [DATA_W-1:0]    rdata
);
    localparam int LANES = DATA_W / 8;
    localparam logic [ADDR_W-3:0] FLAG_WORD = (ADDR_W-2)'(OFS_FLAG_BASE >> 2);

    logic [DATA_W-1:0] packed_flags;
    logic [ADDR_W-3:0] word_ofs;

    // Gather the flag bytes for the addressed group of harts.
    always_comb begin
        packed_flags = '0;
        word_ofs     = addr_word - FLAG_WORD;
        for (int j = 0; j < LANES; j++) begin
            int idx;
            idx = int'(word_ofs) * LANES + j;
            if (idx < NUM_HARTS)
                packed_flags[8*j +: 8] = {6'b0, res_vec[idx], go_vec[idx]};
        end
    end

    // Capture read data for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_any) rdata <= rd_flags ? packed_flags : '0;
    end

    assert_outside_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !rd_flags) |=> (rdata == '0));
endmodule

// File: rtl/dbg_hs_regs.sv
// Module dbg_hs_regs
// Top of the hart handshake bank. Decodes hart-side writes into per-hart
// set and clear strobes, instantiates one state slice per hart, keeps the
// sticky exception bit, and serves flag-region reads.
// Assumes hart IDs in write data are plain binary integers.
module dbg_hs_regs
    import dbg_hs_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int ID_W      = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [ID_W-1:0]      bus_src_hart,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 dbg_go_set,
    input  logic                 dbg_resume_set,
    input  logic [ID_W-1:0]      dbg_hart_sel,
    input  logic                 dbg_exc_clear,
    output logic [NUM_HARTS-1:0] go_flags,
    output logic [NUM_HARTS-1:0] resume_flags,
    output logic [NUM_HARTS-1:0] halted_harts,
    output logic                 exception_seen
);
    hs_evt_t evt;

    dbg_hs_decode #(.ADDR_W(ADDR_W)) i_decode (
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .evt      (evt)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic sel_dbg;
        logic sel_src;
        logic sel_data;

        // Work out which requests target this hart.
        always_comb begin
            sel_dbg  = (dbg_hart_sel == ID_W'(h));
            sel_src  = (bus_src_hart == ID_W'(h));
            sel_data = (bus_wdata == DATA_W'(h));
        end

        dbg_hs_hart_slice i_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_set   (dbg_go_set && sel_dbg),
            .go_clr   (evt.go_ack && sel_src),
            .res_set  (dbg_resume_set && sel_dbg),
            .res_clr  (evt.resume_ack && sel_data),
            .halt_set (evt.halt_rpt && sel_data),
            .go_q     (go_flags[h]),
            .res_q    (resume_flags[h]),
            .halt_q   (halted_harts[h])
        );
    end

    // Sticky exception bit: a report wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             exception_seen <= 1'b0;
        else if (evt.exc_rpt)   exception_seen <= 1'b1;
        else if (dbg_exc_clear) exception_seen <= 1'b0;
    end

    dbg_hs_rdmux #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_any    (evt.rd_any),
        .rd_flags  (evt.rd_flags),
        .addr_word (bus_addr[ADDR_W-1:2]),
        .go_vec    (go_flags),
        .res_vec   (resume_flags),
        .rdata     (bus_rdata)
    );

    assert_exc_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt.exc_rpt |=> exception_seen);
    assert_exc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_exc_clear && !evt.exc_rpt) |=> !exception_seen);
    assert_exc_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exception_seen && !dbg_exc_clear) |=> exception_seen);
    assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !dbg_go_set && !dbg_resume_set) |=>
        ($stable(go_flags) && $stable(resume_flags) && $stable(halted_harts)));
endmodule

// File: tb/test_dbg_hs_regs.sv
module test_dbg_hs_regs;
    localparam int NH = 6;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [IW-1:0] bus_src_hart, dbg_hart_sel;
    logic        dbg_go_set, dbg_resume_set, dbg_exc_clear;
    logic [NH-1:0] go_flags, resume_flags, halted_harts;
    logic        exception_seen;

    int errors = 0;
    int checks = 0;

    logic [NH-1:0] e_go, e_res, e_halt;
    logic          e_exc;

    always #5 clk = ~clk;

    dbg_hs_regs #(.NUM_HARTS(NH), .ADDR_W(12), .DATA_W(32), .ID_W(IW)) i_dbg_hs_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_src_hart(bus_src_hart), .bus_rdata(bus_rdata),
        .dbg_go_set(dbg_go_set), .dbg_resume_set(dbg_resume_set),
        .dbg_hart_sel(dbg_hart_sel), .dbg_exc_clear(dbg_exc_clear),
        .go_flags(go_flags), .resume_flags(resume_flags),
        .halted_harts(halted_harts), .exception_seen(exception_seen)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " go"},     32'(go_flags),       32'(e_go));
        check({req, " resume"}, 32'(resume_flags),   32'(e_res));
        check({req, " halted"}, 32'(halted_harts),   32'(e_halt));
        check({req, " exc"},    32'(exception_seen), 32'(e_exc));
    endtask

    task automatic idle();
        bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; bus_src_hart = '0;
        dbg_go_set = 0; dbg_resume_set = 0; dbg_hart_sel = '0; dbg_exc_clear = 0;
    endtask

    // One bus write, held across one rising edge; state is checked afterwards.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [IW-1:0] src);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_src_hart = src;
        @(negedge clk);
        idle();
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_req = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        idle();
        d = bus_rdata;
    endtask

    task automatic dbg_set(input logic go, input logic res, input logic [IW-1:0] h);
        dbg_go_set = go; dbg_resume_set = res; dbg_hart_sel = h;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        e_go = '0; e_res = '0; e_halt = '0; e_exc = 0;
        check_state("R1 reset");
        bus_read(12'h400, d);
        check("R1 reset read", d, 32'h0);
    endtask

    task automatic t_debugger_set();
        dbg_set(1, 0, 3'd2); e_go[2] = 1;
        check_state("R2 go set hart2");
        dbg_set(0, 1, 3'd5); e_res[5] = 1;
        check_state("R2 resume set hart5");
        dbg_set(1, 0, 3'd7);
        check_state("R2 out-of-range hart");
    endtask

    task automatic t_read_flags();
        logic [31:0] d;
        bus_read(12'h400, d);
        check("R8 read word0", d, 32'h0001_0000);
        bus_read(12'h406, d);
        check("R8 read word1 via lane addr", d, 32'h0000_0200);
        bus_read(12'h408, d);
        check("R8 read beyond harts", d, 32'h0);
    endtask

    task automatic t_halt();
        bus_write(12'h100, 32'd3, 3'd3); e_halt[3] = 1;
        check_state("R5 halt report hart3");
        bus_write(12'h100, 32'd9, 3'd1);
        check_state("R5 halt id out of range");
    endtask

    task automatic t_go_ack();
        dbg_set(1, 0, 3'd1); e_go[1] = 1;
        bus_write(12'h104, 32'hDEAD_BEEF, 3'd2); e_go[2] = 0;
        check_state("R3 go ack hart2 only");
    endtask

    task automatic t_resume_ack();
        dbg_set(0, 1, 3'd3); e_res[3] = 1;
        bus_write(12'h108, 32'd3, 3'd0); e_res[3] = 0; e_halt[3] = 0;
        check_state("R4 resume ack hart3");
    endtask

    task automatic t_clear_priority();
        dbg_go_set = 1; dbg_hart_sel = 3'd1;
        bus_req = 1; bus_we = 1; bus_addr = 12'h104; bus_src_hart = 3'd1;
        @(negedge clk);
        idle(); e_go[1] = 0;
        check_state("R6 go set vs ack");
        dbg_resume_set = 1; dbg_hart_sel = 3'd4;
        bus_req = 1; bus_we = 1; bus_addr = 12'h108; bus_wdata = 32'd4;
        @(negedge clk);
        idle();
        check_state("R6 resume set vs ack");
    endtask

    task automatic t_exception();
        bus_write(12'h10C, 32'h0, 3'd0); e_exc = 1;
        check_state("R7 exception report");
        bus_write(12'h104, 32'h0, 3'd0);
        check_state("R7 exception stays");
        dbg_exc_clear = 1; @(negedge clk); idle(); e_exc = 0;
        check_state("R7 exception cleared");
        dbg_exc_clear = 1; bus_req = 1; bus_we = 1; bus_addr = 12'h10C;
        @(negedge clk); idle(); e_exc = 1;
        check_state("R7 report beats clear");
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        bus_write(12'h400, 32'h0, 3'd5);
        check_state("R9 flag region write ignored");
        bus_write(12'h101, 32'd0, 3'd0);
        check_state("R9 misaligned write ignored");
        bus_req = 0; bus_we = 1; bus_addr = 12'h108; bus_wdata = 32'd5;
        @(negedge clk); idle();
        check_state("R9 no request ignored");
        bus_read(12'h100, d);
        check("R9 read outside region", d, 32'h0);
        bus_read(12'h404, d);
        check("R9 flags kept after ignored writes", d, 32'h0000_0200);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_debugger_set();
        t_read_flags();
        t_halt();
        t_go_ack();
        t_resume_ack();
        t_clear_priority();
        t_exception();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule